// File: doc/BRIEF.md
# Free-Running Timer with Compare and Capture

This peripheral keeps a 16-bit up-counter running on a selectable internal tick. It compares the count against two programmable compare values and, on a rising edge of a capture pin, records the count. The counter can be told to restart from zero when it matches compare A. Overflow, both compare matches and the capture each set a sticky flag in a status register. Software can clear these flags but cannot set them.

The register bus is eight bits wide, so each 16-bit register sits at two byte addresses. One shared temporary byte joins the two halves. Reading a high byte stores the matching low byte in that temporary byte, so a high-then-low pair of reads returns one consistent 16-bit value. Writing a high byte fills only the temporary byte. The following low-byte write then updates the whole 16-bit register in one step.

Top module: `frt_timer`

## Requirements
- R1: Reset values: the counter, the control register, the status register and the capture register are zero, and both compare registers are 0xFFFF.
- R2: The counter rises by one on each tick. Control bits [1:0] choose the tick: 00 = one tick every 2 clocks, 01 = every 8, 10 = every 32, 11 = each rising edge of `ext_clk` after a two-flop synchronizer. With no tick the counter holds.
- R3: A tick that moves the counter from 0xFFFF to 0x0000 sets the overflow flag, status bit 4.
- R4: A tick on which the counter equals compare A sets status bit 6. A tick on which the counter equals compare B sets status bit 5.
- R5: When status bit 0 (clear enable) is 1, a compare-A match tick loads 0x0000 into the counter in place of the increment.
- R6: A synchronized rising edge on `cap_pin` copies the counter into the capture register and sets status bit 7. The capture bytes (addresses 6 high, 7 low) ignore bus writes.
- R7: Writing the status register (address 9) clears each of bits 7..4 whose written bit is 0. A written 1 leaves that bit unchanged. Bits 3..0 take the written value. A set event in the same cycle as a clear keeps the flag at 1.
- R8: Reading a high byte of the counter (address 0) or of the capture register (address 6) returns that high byte and stores the low byte in the temporary byte. Reading address 1 or 7 returns the temporary byte.
- R9: Writing a high byte (address 0, 2 or 4) changes only the temporary byte. Writing the matching low byte (address 1, 3 or 5) loads {temporary, data} into the counter, compare A or compare B. Compare bytes read back directly.
- R10: A counter load from the bus takes priority over a tick in the same cycle. No match or overflow event occurs in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte register address |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| ext_clk | input | 1 | External tick source (asynchronous) |
| cap_pin | input | 1 | Capture trigger (asynchronous) |

## Verification
The assertions rely on the bus never raising read and write strobes in the same cycle. They also rely on every high-byte access being followed by its own low byte before another 16-bit register is touched, because the temporary byte is shared. The stimulus drives these rules directly. It also holds `ext_clk` and `cap_pin` steady for several clocks at each level, so every edge passes the synchronizer exactly once. When the external tick is selected, the pin stays low except during deliberate pulses, so compare, overflow and capture values are exact.

// File: rtl/frt_pkg.sv
package frt_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int PS_W   = 5;

    typedef enum logic [3:0] {
        RA_CNT_HI  = 4'd0,
        RA_CNT_LO  = 4'd1,
        RA_CMPA_HI = 4'd2,
        RA_CMPA_LO = 4'd3,
        RA_CMPB_HI = 4'd4,
        RA_CMPB_LO = 4'd5,
        RA_CAP_HI  = 4'd6,
        RA_CAP_LO  = 4'd7,
        RA_CTRL    = 4'd8,
        RA_STAT    = 4'd9
    } reg_addr_e;

    typedef enum logic [1:0] {
        TK_DIV2  = 2'b00,
        TK_DIV8  = 2'b01,
        TK_DIV32 = 2'b10,
        TK_EXT   = 2'b11
    } tick_sel_e;

    // flag nibble occupies status bits 7..4 in this order
    typedef struct packed {
        logic cap;
        logic cmpa;
        logic cmpb;
        logic ovf;
    } evt_t;

    localparam int STAT_CLR_EN = 0;

    function automatic logic div_hit(input logic [PS_W-1:0] div, input tick_sel_e sel);
        case (sel)
            TK_DIV2:  return div[0];
            TK_DIV8:  return &div[2:0];
            TK_DIV32: return &div[4:0];
            default:  return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/frt_sync_edge.sv
module frt_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], din};
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/frt_prescaler.sv
module frt_prescaler
    import frt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  tick_sel_e sel,
    input  logic      ext_in,
    output logic      tick
);
    logic [PS_W-1:0] div;
    logic            ext_rise;

    always_ff @(posedge clk) begin
        if (rst) div <= '0;
        else     div <= div + 1'b1;
    end

    frt_sync_edge #(.STAGES(SYNC_STAGES)) i_ext_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (ext_in),
        .rise (ext_rise)
    );

    assign tick = (sel == TK_EXT) ? ext_rise : div_hit(div, sel);
endmodule

// File: rtl/frt_count_core.sv
module frt_count_core
    import frt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] cmpa,
    input  logic [CNT_W-1:0] cmpb,
    input  logic             clr_en,
    output logic [CNT_W-1:0] cnt,
    output logic             evt_cmpa,
    output logic             evt_cmpb,
    output logic             evt_ovf
);
    localparam logic [CNT_W-1:0] TOP = '1;

    logic live;
    assign live     = tick & ~load;
    assign evt_cmpa = live & (cnt == cmpa);
    assign evt_cmpb = live & (cnt == cmpb);
    assign evt_ovf  = live & (cnt == TOP);

    always_ff @(posedge clk) begin
        if (rst)                     cnt <= '0;
        else if (load)               cnt <= load_val;
        else if (evt_cmpa && clr_en) cnt <= '0;
        else if (live)               cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/frt_timer.sv
module frt_timer
    import frt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              ext_clk,
    input  logic              cap_pin
);
    reg_addr_e         ra;
    logic [BYTE_W-1:0] ctrl_q, stat_q, temp_q;
    logic [CNT_W-1:0]  cmpa_q, cmpb_q, cap_q, cnt, load_val;
    logic              tick, cnt_load, stat_wr, cap_evt;
    logic              evt_cmpa, evt_cmpb, evt_ovf;
    evt_t              set_ev, keep_fl;

    assign ra       = reg_addr_e'(bus_addr);
    assign cnt_load = bus_wr && (ra == RA_CNT_LO);
    assign stat_wr  = bus_wr && (ra == RA_STAT);
    assign load_val = {temp_q, bus_wdata};

    frt_prescaler #(.SYNC_STAGES(SYNC_STAGES)) i_pre (
        .clk    (clk),
        .rst    (rst),
        .sel    (tick_sel_e'(ctrl_q[1:0])),
        .ext_in (ext_clk),
        .tick   (tick)
    );

    frt_sync_edge #(.STAGES(SYNC_STAGES)) i_cap_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (cap_pin),
        .rise (cap_evt)
    );

    frt_count_core i_core (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load     (cnt_load),
        .load_val (load_val),
        .cmpa     (cmpa_q),
        .cmpb     (cmpb_q),
        .clr_en   (stat_q[STAT_CLR_EN]),
        .cnt      (cnt),
        .evt_cmpa (evt_cmpa),
        .evt_cmpb (evt_cmpb),
        .evt_ovf  (evt_ovf)
    );

    assign set_ev  = '{cap: cap_evt, cmpa: evt_cmpa, cmpb: evt_cmpb, ovf: evt_ovf};
    assign keep_fl = stat_wr ? evt_t'(stat_q[7:4] & bus_wdata[7:4]) : evt_t'(stat_q[7:4]);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            stat_q <= '0;
            temp_q <= '0;
            cmpa_q <= '1;
            cmpb_q <= '1;
            cap_q  <= '0;
        end else begin
            stat_q[7:4] <= keep_fl | set_ev;
            if (stat_wr)                     stat_q[3:0] <= bus_wdata[3:0];
            if (bus_wr && ra == RA_CTRL)     ctrl_q <= bus_wdata;
            if (bus_wr && ra == RA_CMPA_LO)  cmpa_q <= load_val;
            if (bus_wr && ra == RA_CMPB_LO)  cmpb_q <= load_val;
            if (cap_evt)                     cap_q  <= cnt;
            if (bus_wr && (ra == RA_CNT_HI || ra == RA_CMPA_HI || ra == RA_CMPB_HI))
                temp_q <= bus_wdata;
            else if (bus_rd && ra == RA_CNT_HI)
                temp_q <= cnt[BYTE_W-1:0];
            else if (bus_rd && ra == RA_CAP_HI)
                temp_q <= cap_q[BYTE_W-1:0];
        end
    end

    always_comb begin
        case (ra)
            RA_CNT_HI:  bus_rdata = cnt[CNT_W-1:BYTE_W];
            RA_CNT_LO:  bus_rdata = temp_q;
            RA_CMPA_HI: bus_rdata = cmpa_q[CNT_W-1:BYTE_W];
            RA_CMPA_LO: bus_rdata = cmpa_q[BYTE_W-1:0];
            RA_CMPB_HI: bus_rdata = cmpb_q[CNT_W-1:BYTE_W];
            RA_CMPB_LO: bus_rdata = cmpb_q[BYTE_W-1:0];
            RA_CAP_HI:  bus_rdata = cap_q[CNT_W-1:BYTE_W];
            RA_CAP_LO:  bus_rdata = temp_q;
            RA_CTRL:    bus_rdata = ctrl_q;
            RA_STAT:    bus_rdata = stat_q;
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/frt_timer_chk.sv
module frt_timer_chk (
    input logic        clk,
    input logic        rst,
    input logic        tick,
    input logic        cnt_load,
    input logic [15:0] load_val,
    input logic [15:0] cnt,
    input logic [15:0] cmpa,
    input logic        clr_en,
    input logic [3:0]  flags,
    input logic        stat_wr,
    input logic        cap_evt,
    input logic [15:0] cap
);
    p_cnt_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !cnt_load) |=> cnt == $past(cnt));

    p_cnt_step_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_load && !(clr_en && cnt == cmpa)) |=> cnt == $past(cnt) + 16'd1);

    p_ovf_set_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_load && cnt == 16'hFFFF) |=> flags[0]);

    p_clear_on_a_r5: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_load && clr_en && cnt == cmpa) |=> cnt == 16'h0000);

    p_cap_copy_r6: assert property (@(posedge clk) disable iff (rst)
        cap_evt |=> (cap == $past(cnt)) && flags[3]);

    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        !stat_wr |=> (flags & $past(flags)) == $past(flags));

    p_load_wins_r10: assert property (@(posedge clk) disable iff (rst)
        cnt_load |=> cnt == $past(load_val));
endmodule

bind frt_timer frt_timer_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .cnt_load (cnt_load),
    .load_val (load_val),
    .cnt      (cnt),
    .cmpa     (cmpa_q),
    .clr_en   (stat_q[0]),
    .flags    (stat_q[7:4]),
    .stat_wr  (stat_wr),
    .cap_evt  (cap_evt),
    .cap      (cap_q)
);

// File: tb/test_frt_timer.sv
module test_frt_timer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] bus_addr = 4'd0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       ext_clk = 1'b0, cap_pin = 1'b0;

    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    frt_timer i_frt_timer (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk(ext_clk), .cap_pin(cap_pin)
    );

    // behavioural reference model
    logic [15:0] m_cnt, m_cmpa, m_cmpb, m_cap;
    logic [7:0]  m_ctrl, m_stat, m_temp;
    logic [4:0]  m_div;
    logic [2:0]  m_ext, m_csh;

    always @(posedge clk) begin
        logic tk, ld, ea, eb, eo, ec;
        logic [3:0] fl;
        logic [15:0] nc, ncap;
        logic [7:0] ntemp;
        if (rst) begin
            m_cnt = 0; m_cmpa = 16'hFFFF; m_cmpb = 16'hFFFF; m_cap = 0;
            m_ctrl = 0; m_stat = 0; m_temp = 0; m_div = 0; m_ext = 0; m_csh = 0;
        end else begin
            case (m_ctrl[1:0])
                2'd0:    tk = (m_div % 2) == 1;
                2'd1:    tk = (m_div % 8) == 7;
                2'd2:    tk = (m_div % 32) == 31;
                default: tk = m_ext[1] && !m_ext[2];
            endcase
            ec = m_csh[1] && !m_csh[2];
            ld = bus_wr && bus_addr == 4'd1;
            ea = tk && !ld && m_cnt == m_cmpa;
            eb = tk && !ld && m_cnt == m_cmpb;
            eo = tk && !ld && m_cnt == 16'hFFFF;
            if (ld)                 nc = {m_temp, bus_wdata};
            else if (ea && m_stat[0]) nc = 0;
            else if (tk)            nc = m_cnt + 16'd1;
            else                    nc = m_cnt;
            ncap = ec ? m_cnt : m_cap;
            ntemp = m_temp;
            if (bus_wr && (bus_addr == 0 || bus_addr == 2 || bus_addr == 4)) ntemp = bus_wdata;
            else if (bus_rd && bus_addr == 0) ntemp = m_cnt[7:0];
            else if (bus_rd && bus_addr == 6) ntemp = m_cap[7:0];
            if (bus_wr && bus_addr == 3) m_cmpa = {m_temp, bus_wdata};
            if (bus_wr && bus_addr == 5) m_cmpb = {m_temp, bus_wdata};
            if (bus_wr && bus_addr == 8) m_ctrl = bus_wdata;
            fl = m_stat[7:4];
            if (bus_wr && bus_addr == 9) begin
                fl = fl & bus_wdata[7:4];
                m_stat[3:0] = bus_wdata[3:0];
            end
            fl = fl | {ec, ea, eb, eo};
            m_stat[7:4] = fl;
            m_cnt = nc; m_cap = ncap; m_temp = ntemp;
            m_div = m_div + 5'd1;
            m_ext = {m_ext[1:0], ext_clk};
            m_csh = {m_csh[1:0], cap_pin};
        end
    end

    function automatic logic [7:0] m_read(input logic [3:0] a);
        case (a)
            4'd0: return m_cnt[15:8];
            4'd1: return m_temp;
            4'd2: return m_cmpa[15:8];
            4'd3: return m_cmpa[7:0];
            4'd4: return m_cmpb[15:8];
            4'd5: return m_cmpb[7:0];
            4'd6: return m_cap[15:8];
            4'd7: return m_temp;
            4'd8: return m_ctrl;
            4'd9: return m_stat;
            default: return 8'd0;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] a);
        case (a)
            4'd0, 4'd1: return "R2 model counter";
            4'd2, 4'd3, 4'd4, 4'd5: return "R9 model compare";
            4'd6, 4'd7: return "R6 model capture";
            4'd9: return "R7 model status";
            default: return "R2 model control";
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // every-clock comparison against the model
    always begin
        @(posedge clk);
        #5;
        if (!rst) check(req_of(bus_addr), {8'd0, bus_rdata}, {8'd0, m_read(bus_addr)});
    end

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            bus_rd = 1'b0; bus_wr = 1'b0;
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #5 v = bus_rdata;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string req);
        logic [7:0] v;
        rd(a, v);
        check(req, {8'd0, v}, {8'd0, exp});
    endtask

    task automatic wr16(input logic [3:0] hi_a, input logic [15:0] d);
        wr(hi_a, d[15:8]);
        wr(hi_a + 4'd1, d[7:0]);
    endtask

    task automatic ext_pulse();
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0; ext_clk = 1'b1;
        idle(3);
        @(negedge clk);
        ext_clk = 1'b0;
        idle(4);
    endtask

    task automatic read16(input logic [3:0] hi_a, output logic [15:0] v);
        logic [7:0] h, l;
        rd(hi_a, h);
        rd(hi_a + 4'd1, l);
        v = {h, l};
    endtask

    task automatic rate_chk(input logic [1:0] sel, input logic [15:0] delta, input string req);
        logic [15:0] a, b;
        wr(4'd8, {6'd0, sel});
        idle(4);
        read16(4'd0, a);
        idle(62);
        read16(4'd0, b);
        check(req, b - a, delta);
    endtask

    task automatic run_tests();
        // R1: reset values, read while reset is held
        rd_chk(4'd0, 8'h00, "R1 counter high");
        rd_chk(4'd2, 8'hFF, "R1 compare A high");
        rd_chk(4'd3, 8'hFF, "R1 compare A low");
        rd_chk(4'd4, 8'hFF, "R1 compare B high");
        rd_chk(4'd5, 8'hFF, "R1 compare B low");
        rd_chk(4'd6, 8'h00, "R1 capture high");
        rd_chk(4'd8, 8'h00, "R1 control");
        rd_chk(4'd9, 8'h00, "R1 status");
        @(negedge clk);
        bus_rd = 1'b0;
        rst = 1'b0;

        // external tick selected, pin idle: counter frozen
        wr(4'd8, 8'h03);
        // R9: 16-bit write through temporary byte
        wr16(4'd0, 16'h1234);
        rd_chk(4'd0, 8'h12, "R9 counter high after pair");
        rd_chk(4'd1, 8'h34, "R9 counter low after pair");
        wr(4'd0, 8'h56);
        rd_chk(4'd0, 8'h12, "R9 high write alone leaves counter");
        rd_chk(4'd1, 8'h34, "R9 high write alone leaves counter low");

        // R8: coherent read while the counter moves
        wr16(4'd0, 16'h12FE);
        rd_chk(4'd0, 8'h12, "R8 high read");
        ext_pulse();
        rd_chk(4'd1, 8'hFE, "R8 low read returns latched byte");
        rd_chk(4'd0, 8'h12, "R8 high read again");
        rd_chk(4'd1, 8'hFF, "R2 external tick advanced counter");

        // R3/R4: wrap with both compares at reset value
        wr16(4'd0, 16'hFFFF);
        ext_pulse();
        rd_chk(4'd9, 8'h70, "R3 overflow plus R4 matches at FFFF");
        rd_chk(4'd0, 8'h00, "R3 counter wrapped high");
        rd_chk(4'd1, 8'h00, "R3 counter wrapped low");

        // R7: write-zero-to-clear
        wr(4'd9, 8'hEF);
        rd_chk(4'd9, 8'h6F, "R7 clear overflow only, low nibble written");
        wr(4'd9, 8'hF0);
        rd_chk(4'd9, 8'h60, "R7 ones leave flags");
        wr(4'd9, 8'h00);
        rd_chk(4'd9, 8'h00, "R7 zeros clear flags");

        // R4: compare B alone
        wr16(4'd4, 16'h0010);
        rd_chk(4'd5, 8'h10, "R9 compare B low readback");
        wr16(4'd0, 16'h0010);
        ext_pulse();
        rd_chk(4'd9, 8'h20, "R4 compare B flag");
        wr(4'd9, 8'h00);

        // R5: clear on compare A
        wr(4'd9, 8'h01);
        wr16(4'd2, 16'h0003);
        wr16(4'd0, 16'h0002);
        ext_pulse();
        ext_pulse();
        rd_chk(4'd0, 8'h00, "R5 cleared high");
        rd_chk(4'd1, 8'h00, "R5 cleared low");
        rd_chk(4'd9, 8'h41, "R4 compare A flag with clear enable");
        wr(4'd9, 8'h00);
        wr16(4'd0, 16'h0003);
        ext_pulse();
        rd_chk(4'd0, 8'h00, "R5 no clear when disabled high");
        rd_chk(4'd1, 8'h04, "R5 no clear when disabled low");
        rd_chk(4'd9, 8'h40, "R4 compare A flag");
        wr(4'd9, 8'h00);

        // R6: capture and write immunity
        wr16(4'd0, 16'h0ABC);
        @(negedge clk);
        bus_wr = 1'b0; cap_pin = 1'b1;
        idle(4);
        @(negedge clk);
        cap_pin = 1'b0;
        idle(4);
        rd_chk(4'd9, 8'h80, "R6 capture flag");
        rd_chk(4'd6, 8'h0A, "R6 capture high");
        rd_chk(4'd7, 8'hBC, "R6 capture low via temp");
        wr(4'd6, 8'h55);
        wr(4'd7, 8'h66);
        rd_chk(4'd6, 8'h0A, "R6 capture high ignores writes");
        rd_chk(4'd7, 8'hBC, "R6 capture low ignores writes");

        // R7: set wins over a coincident clear
        wr(4'd9, 8'h00);
        @(negedge clk);
        bus_wr = 1'b0; cap_pin = 1'b1;
        idle(1);
        wr(4'd9, 8'h00);
        idle(3);
        @(negedge clk);
        cap_pin = 1'b0;
        idle(4);
        rd_chk(4'd9, 8'h80, "R7 set event wins over clear");
        wr(4'd9, 8'h00);

        // R2: prescaler rates over 64 clocks
        rate_chk(2'b00, 16'd32, "R2 divide by 2 rate");
        rate_chk(2'b01, 16'd8,  "R2 divide by 8 rate");
        rate_chk(2'b10, 16'd2,  "R2 divide by 32 rate");

        // R10: load wins over a tick, both prescaler phases
        wr(4'd8, 8'h00);
        for (int i = 0; i < 2; i++) begin
            wr16(4'd0, 16'h4000);
            rd_chk(4'd0, 8'h40, "R10 load wins high");
            rd_chk(4'd1, 8'h00, "R10 load wins low");
            idle(1);
        end
        idle(4);
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (150000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule